// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block collects interrupt requests from five sources: two external lines, two timers and one combined serial line. It turns them into one vectored request to the processor. Each source has its own enable bit and a one-bit level select. A global enable gates all sources at once. When a request is issued, the block presents the code address of the chosen service routine. Every source has a fixed slot, and the slots lie eight bytes apart from 0003H upward. Address 0000H stays reserved for the reset entry point.

The processor takes a request by pulsing the acknowledge input. On that pulse the block marks the request's level as in service. It then holds back every request that may not interrupt the running routine. A high-level request may preempt a low-level routine. Nothing preempts a high-level routine, and a low-level request never preempts a low-level routine. A return pulse closes the innermost active routine, so the block unwinds nested levels in the right order. Request flags are level inputs, and capturing edges or clearing flags is left to the source peripherals.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_o`, `irq_hi_o`, `act_lo_o` and `act_hi_o` are 0 and `vec_o` is 0000H.
- R2: A request issued for source index i (0 ext-A, 1 timer-A, 2 ext-B, 3 timer-B, 4 serial) gives `vec_o` = 0003H + 8·i, that is 0003H, 000BH, 0013H, 001BH, 0023H. These values appear one clock after the inputs that select them.
- R3: While `glb_en_i` is 0, no request is issued on the following clock.
- R4: A source whose `src_en_i` bit is 0 never causes a request.
- R5: Among eligible requests of the same level, the lowest source index wins.
- R6: An eligible high-level request (`src_hi_i` bit = 1) wins over any low-level request regardless of index, and `irq_hi_o` shows the issued level.
- R7: `ack_i` while `irq_o` is 1 sets the in-service flag of the issued level (`act_hi_o` or `act_lo_o`) on that clock.
- R8: While only the low level is in service, only high-level requests are issued. Low-level requests are held back.
- R9: While the high level is in service, no request is issued.
- R10: `reti_i` clears `act_hi_o` if it is set, otherwise `act_lo_o`. Held-back requests are issued from the same clock on.
- R11: `ack_i` while `irq_o` is 0 leaves both in-service flags unchanged.
- R12: While `irq_o` is 0, `vec_o` is 0000H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Request flags, one per source |
| glb_en_i | input | 1 | Global enable |
| src_en_i | input | 5 | Per-source enable |
| src_hi_i | input | 5 | Per-source level select, 1 = high |
| ack_i | input | 1 | Processor accepts the issued request |
| reti_i | input | 1 | Return from the current service routine |
| irq_o | output | 1 | Request to the processor |
| irq_hi_o | output | 1 | Level of the issued request |
| vec_o | output | 16 | Service routine address, 0000H when idle |
| act_lo_o | output | 1 | Low level in service |
| act_hi_o | output | 1 | High level in service |

## Verification
The bench builds the block with its default parameters: five sources, base 0003H, stride 8 and 16-bit addresses. With these values every vector slot up to the serial slot at 0023H can be reached. All pairings of level against index can also be reached, including a high request at the last index beating low requests at lower indices. The directed nesting scenario goes through a full low-to-high preemption and unwinds it with two returns. It checks that held-back requests appear in the clock right after each return.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } irq_lvl_e;

  localparam int NUM_LVL = 2;
endpackage

// File: rtl/irq_qual.sv
module irq_qual #(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] src_hi_i,
  output logic [NUM_SRC-1:0] cand_lo_o,
  output logic [NUM_SRC-1:0] cand_hi_o
);
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    elig      = req_i & src_en_i & {NUM_SRC{glb_en_i}};
    cand_hi_o = elig & src_hi_i;
    cand_lo_o = elig & ~src_hi_i;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] cand_i,
  output logic               any_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC:0] blocked;

  assign blocked[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_chain
      assign blocked[gi+1] = blocked[gi] | cand_i[gi];
      assign grant_o[gi]   = cand_i[gi] & ~blocked[gi];
    end
  endgenerate

  assign any_o = blocked[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  output logic act_lo_q_o,
  output logic act_hi_q_o,
  output logic act_lo_nxt_o,
  output logic act_hi_nxt_o
);
  logic act_lo_q, act_hi_q;
  logic act_lo_d, act_hi_d;
  logic lo_after_ret, hi_after_ret;
  logic accept;

  always_comb begin
    hi_after_ret = act_hi_q;
    lo_after_ret = act_lo_q;
    if (reti_i) begin
      if (act_hi_q) hi_after_ret = 1'b0;
      else          lo_after_ret = 1'b0;
    end
    accept   = ack_i & take_i;
    act_hi_d = hi_after_ret | (accept & take_hi_i);
    act_lo_d = lo_after_ret | (accept & ~take_hi_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo_q <= 1'b0;
      act_hi_q <= 1'b0;
    end else begin
      act_lo_q <= act_lo_d;
      act_hi_q <= act_hi_d;
    end
  end

  assign act_lo_q_o   = act_lo_q;
  assign act_hi_q_o   = act_hi_q;
  assign act_lo_nxt_o = act_lo_d;
  assign act_hi_nxt_o = act_hi_d;

  AST_ACK_SETS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && take_i && take_hi_i) |=> act_hi_q); // R7
  AST_ACK_SETS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && take_i && !take_hi_i) |=> act_lo_q); // R7
  AST_RETI_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && act_hi_q && !ack_i) |=> !act_hi_q); // R10
  AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !take_i && !reti_i) |=> ($stable(act_hi_q) && $stable(act_lo_q))); // R11
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NUM_SRC    = 5,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] src_hi_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic               irq_hi_o,
  output logic [ADDR_W-1:0]  vec_o,
  output logic               act_lo_o,
  output logic               act_hi_o
);
  import irq_vec_pkg::*;

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_LVL-1:0][NUM_SRC-1:0] cand;
  logic [NUM_LVL-1:0][NUM_SRC-1:0] grant;
  logic [NUM_LVL-1:0][IDX_W-1:0]   lvl_idx;
  logic [NUM_LVL-1:0]              lvl_any;

  logic act_lo_q, act_hi_q, act_lo_nxt, act_hi_nxt;

  logic              irq_d, irq_q;
  irq_lvl_e          lvl_d, lvl_q;
  logic [IDX_W-1:0]  idx_d;
  logic [ADDR_W-1:0] vec_d, vec_q;
  logic              upd_en;

  irq_qual #(.NUM_SRC(NUM_SRC)) u_qual (
    .req_i     (req_i),
    .glb_en_i  (glb_en_i),
    .src_en_i  (src_en_i),
    .src_hi_i  (src_hi_i),
    .cand_lo_o (cand[LVL_LO]),
    .cand_hi_o (cand[LVL_HI])
  );

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LVL; gl++) begin : g_lvl
      irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .cand_i  (cand[gl]),
        .any_o   (lvl_any[gl]),
        .grant_o (grant[gl]),
        .idx_o   (lvl_idx[gl])
      );
    end
  endgenerate

  irq_svc_track u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .take_i       (irq_q),
    .take_hi_i    (lvl_q == LVL_HI),
    .reti_i       (reti_i),
    .act_lo_q_o   (act_lo_q),
    .act_hi_q_o   (act_hi_q),
    .act_lo_nxt_o (act_lo_nxt),
    .act_hi_nxt_o (act_hi_nxt)
  );

  // Next-state: arbitrate against the in-service state that will hold after this clock.
  always_comb begin
    irq_d = 1'b0;
    lvl_d = LVL_LO;
    idx_d = '0;
    if (lvl_any[LVL_HI] && !act_hi_nxt) begin
      irq_d = 1'b1;
      lvl_d = LVL_HI;
      idx_d = lvl_idx[LVL_HI];
    end else if (lvl_any[LVL_LO] && !act_hi_nxt && !act_lo_nxt) begin
      irq_d = 1'b1;
      lvl_d = LVL_LO;
      idx_d = lvl_idx[LVL_LO];
    end
    vec_d  = irq_d ? (ADDR_W'(VEC_BASE) + ADDR_W'(idx_d) * ADDR_W'(VEC_STRIDE)) : '0;
    upd_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      lvl_q <= LVL_LO;
      vec_q <= '0;
    end else if (upd_en) begin
      irq_q <= irq_d;
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign irq_o    = irq_q;
  assign irq_hi_o = (lvl_q == LVL_HI) & irq_q;
  assign vec_o    = vec_q;
  assign act_lo_o = act_lo_q;
  assign act_hi_o = act_hi_q;

  AST_GLB_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |=> !irq_o); // R3
  AST_SRC_EN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_i & src_en_i)) |=> !irq_o); // R4
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant[LVL_LO]) && $onehot0(grant[LVL_HI])); // R5
  AST_VEC_NOT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o != '0)); // R2
  AST_LO_ACT_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lo_o && irq_o) |-> irq_hi_o); // R8
  AST_HI_ACT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    act_hi_o |-> !irq_o); // R9
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  req, en, hi;
  logic        glb, ack, reti;
  logic        irq, irq_hi, act_lo, act_hi;
  logic [15:0] vec;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .glb_en_i(glb), .src_en_i(en),
    .src_hi_i(hi), .ack_i(ack), .reti_i(reti), .irq_o(irq), .irq_hi_o(irq_hi),
    .vec_o(vec), .act_lo_o(act_lo), .act_hi_o(act_hi)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; en = '1; hi = '0; glb = 1'b1; ack = 1'b0; reti = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq", 16'(irq), 16'd0);
    check("R1 vec", vec, 16'h0000);
    check("R1 act_lo", 16'(act_lo), 16'd0);
    check("R1 act_hi", 16'(act_hi), 16'd0);
  endtask

  task automatic t_vectors();
    do_reset();
    for (int i = 0; i < 5; i++) begin
      req = 5'(1 << i);
      tick();
      check("R2 irq", 16'(irq), 16'd1);
      check("R2 vec", vec, 16'(3 + 8 * i));
      req = '0;
      tick();
      check("R12 irq", 16'(irq), 16'd0);
      check("R12 vec", vec, 16'h0000);
    end
  endtask

  task automatic t_gating();
    do_reset();
    glb = 1'b0; req = '1;
    tick();
    check("R3 glb off", 16'(irq), 16'd0);
    glb = 1'b1; en = 5'b11011; req = 5'b00100;
    tick();
    check("R4 masked src", 16'(irq), 16'd0);
    req = 5'b01100;
    tick();
    check("R4 next src vec", vec, 16'h001B);
  endtask

  task automatic t_order();
    do_reset();
    req = 5'b11110;
    tick();
    check("R5 order a", vec, 16'h000B);
    req = 5'b11000;
    tick();
    check("R5 order b", vec, 16'h001B);
    hi = 5'b10000; req = 5'b11111;
    tick();
    check("R6 hi wins vec", vec, 16'h0023);
    check("R6 irq_hi", 16'(irq_hi), 16'd1);
    hi = 5'b10100; req = 5'b10101;
    tick();
    check("R6 hi order vec", vec, 16'h0013);
  endtask

  task automatic t_nesting();
    do_reset();
    hi = 5'b00100; req = 5'b00001;
    tick();
    check("R7 low issued", vec, 16'h0003);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    check("R7 act_lo set", 16'(act_lo), 16'd1);
    check("R8 low held", 16'(irq), 16'd0);
    req = 5'b00101;
    tick();
    check("R8 hi preempts", vec, 16'h0013);
    check("R8 hi level", 16'(irq_hi), 16'd1);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    check("R7 act_hi set", 16'(act_hi), 16'd1);
    check("R9 silent", 16'(irq), 16'd0);
    tick();
    check("R9 still silent", 16'(irq), 16'd0);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    check("R10 hi cleared", 16'(act_hi), 16'd0);
    check("R10 lo kept", 16'(act_lo), 16'd1);
    check("R10 hi reissued", vec, 16'h0013);
    req = 5'b00001;
    tick();
    check("R8 low blocked", 16'(irq), 16'd0);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    check("R10 lo cleared", 16'(act_lo), 16'd0);
    check("R10 low reissued", vec, 16'h0003);
  endtask

  task automatic t_idle_ack();
    do_reset();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    check("R11 act_lo", 16'(act_lo), 16'd0);
    check("R11 act_hi", 16'(act_hi), 16'd0);
    req = 5'b00010;
    tick();
    check("R11 still issues", vec, 16'h000B);
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_gating();
    t_order();
    t_nesting();
    t_idle_ack();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule